// File: doc/BRIEF.md
# BCD Decade Rate Multiplier

This block passes on a programmable fraction of the events that arrive on a single-cycle strobe. The fraction is a two-digit decimal value held as two BCD digits: a tens digit and a units digit. For every 100 strobes taken while the block is enabled, it emits exactly as many output events as the decimal value, and it spreads them through the window rather than bunching them. A typical user is a fractional frequency divider, which needs a given share of its divider cycles to run one input pulse short.

Two decade counters run in cascade, and both advance only on an enabled strobe. The fast counter sees every strobe. The slow counter moves once for each wrap of the fast one. Each digit is gated against one counter's state through fixed binary-weighted slot patterns. The combined gate fires on the strobe cycle itself. Each firing loads a stretcher, which holds the early flag high for a parameterised number of clock cycles. A synchroniser that runs at a slower pace can then catch the flag reliably.

Top module: `dec_rate_mult`

## Requirements
- R1: The tens digit is `tens_i[3:0]` and the units digit is `units_i[3:0]`, both plain BCD. The rate value is 10*tens + units.
- R2: The enabled strobes after reset form windows of 100. Each window produces exactly as many output events as the rate value, for every value from 00 to 99 (for example 01, 32, 50 and 99).
- R3: A strobe taken while `en_i` is low is ignored: it produces no event and does not move the window position. The next enabled window still yields the exact count.
- R4: A digit above 9 counts as 9. A rate value of 00 produces no event at all.
- R5: An event on an enabled strobe at a clock edge drives `early_o` high for exactly HOLD_CYC cycles, starting after that edge. `early_o` rises only after such a strobe.
- R6: Windows split into aligned groups of 10 enabled strobes. Each group carries either `tens` or `tens+1` events, which spreads the output evenly through the window.
- R7: A synchronous reset `rst_i` clears both decade counters and the stretcher. `early_o` is low after the reset edge, and the 100-strobe window restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Single-cycle event to be rate-multiplied |
| en_i | input | 1 | Counting and output enable |
| tens_i | input | 4 | Tens BCD digit of the rate |
| units_i | input | 4 | Units BCD digit of the rate |
| early_o | output | 1 | Stretched output flag |

## Verification
The hardest situation to reach is a window in which disabled strobes, a mid-window reset or out-of-range digits would reveal a counter that moves when it should hold. A single short window cannot show this. The stimulus therefore mixes randomly placed disabled strobes into complete 100-strobe windows. It resets in the middle of a window before counting a fresh one, and it drives random digits from 0 to 15. Every window is checked for its exact total and for its per-group spread.

// File: rtl/rm_pkg.sv
package rm_pkg;
    localparam int          DIG_W   = 4;
    localparam int          N_DIGIT = 2;
    localparam logic [3:0]  DEC_TOP = 4'd9;
    typedef logic [DIG_W-1:0] bcd_t;
endpackage

// File: rtl/rm_digit_clamp.sv
module rm_digit_clamp
    import rm_pkg::*;
(
    input  bcd_t raw_i,
    output bcd_t val_o
);
    always_comb begin
        val_o = (raw_i > DEC_TOP) ? DEC_TOP : raw_i;
    end
endmodule

// File: rtl/rm_weight_gate.sv
module rm_weight_gate
    import rm_pkg::*;
(
    input  bcd_t slot_i,
    input  bcd_t digit_i,
    output logic hit_o
);
    logic w8, w4, w2, w1;

    // Disjoint slot sets of sizes 4, 2 and 1; the size-8 set avoids the
    // size-1 set. Slot 9 belongs to no set: it is kept for the cascade.
    always_comb begin
        w8 = 1'b0;
        w4 = 1'b0;
        w2 = 1'b0;
        w1 = 1'b0;
        case (slot_i)
            4'd0: w8 = 1'b1;
            4'd1: begin w8 = 1'b1; w4 = 1'b1; end
            4'd2: begin w8 = 1'b1; w2 = 1'b1; end
            4'd3: begin w8 = 1'b1; w4 = 1'b1; end
            4'd4: w1 = 1'b1;
            4'd5: w8 = 1'b1;
            4'd6: begin w8 = 1'b1; w4 = 1'b1; end
            4'd7: begin w8 = 1'b1; w2 = 1'b1; end
            4'd8: begin w8 = 1'b1; w4 = 1'b1; end
            default: ;
        endcase
        hit_o = (digit_i[3] & w8) | (digit_i[2] & w4)
              | (digit_i[1] & w2) | (digit_i[0] & w1);
    end
endmodule

// File: rtl/dec_rate_mult.sv
module dec_rate_mult
    import rm_pkg::*;
#(
    parameter int HOLD_CYC = 200
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       strobe_i,
    input  logic       en_i,
    input  logic [3:0] tens_i,
    input  logic [3:0] units_i,
    output logic       early_o
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);

    typedef struct packed {
        bcd_t              fast;
        bcd_t              slow;
        logic [HOLD_W-1:0] hold;
    } st_t;

    st_t  st_q, st_d;
    bcd_t raw  [N_DIGIT];
    bcd_t dig  [N_DIGIT];
    bcd_t slot [N_DIGIT];
    logic hit  [N_DIGIT];
    logic step, fast_end, fire;

    // index 0 = units digit (slow counter), index 1 = tens digit (fast counter)
    assign raw[0]  = units_i;
    assign raw[1]  = tens_i;
    assign slot[0] = st_q.slow;
    assign slot[1] = st_q.fast;

    for (genvar g = 0; g < N_DIGIT; g++) begin : g_digit
        rm_digit_clamp u_clamp (
            .raw_i (raw[g]),
            .val_o (dig[g])
        );
        rm_weight_gate u_gate (
            .slot_i  (slot[g]),
            .digit_i (dig[g]),
            .hit_o   (hit[g])
        );
    end

    always_comb begin
        step     = strobe_i & en_i;
        fast_end = (st_q.fast == DEC_TOP);
        fire     = step & (hit[1] | (hit[0] & fast_end));

        st_d = st_q;
        if (step) begin
            st_d.fast = fast_end ? '0 : st_q.fast + 1'b1;
            if (fast_end) begin
                st_d.slow = (st_q.slow == DEC_TOP) ? '0 : st_q.slow + 1'b1;
            end
        end
        if (fire) begin
            st_d.hold = HOLD_LOAD;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign early_o = (st_q.hold != '0);
endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
    parameter int HOLD_CYC = 200
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       strobe_i,
    input logic       en_i,
    input logic [3:0] tens_i,
    input logic [3:0] units_i,
    input logic       early_o
);
    logic        live_q = 1'b0;
    logic [15:0] run_q  = '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            live_q <= 1'b1;
            run_q  <= '0;
        end else if (early_o) begin
            run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> !early_o); // R7

    AST_RISE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && $rose(early_o)) |-> $past(strobe_i && en_i)); // R5

    AST_ZERO_RATE_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && strobe_i && en_i && tens_i == 4'd0 && units_i == 4'd0)
        |=> !$rose(early_o)); // R4

    AST_HOLD_LENGTH: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && $fell(early_o) && !$past(rst_i)) |-> (run_q >= 16'(HOLD_CYC))); // R5

    AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && strobe_i && !en_i && !early_o) |=> !early_o); // R3
endmodule

bind dec_rate_mult rm_checker #(.HOLD_CYC(HOLD_CYC)) u_rm_checker (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .en_i     (en_i),
    .tens_i   (tens_i),
    .units_i  (units_i),
    .early_o  (early_o)
);

// File: tb/dec_rate_mult_test.sv
module dec_rate_mult_test;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic       en = 1'b0;
    logic [3:0] tens = '0;
    logic [3:0] units = '0;
    logic       early;

    int n_cmp = 0;
    int n_bad = 0;
    int rises = 0;
    int runs = 0;
    int run_len = 0;
    int run_bad = 0;
    logic prev_e = 1'b0;

    always #4 clk = ~clk;

    dec_rate_mult #(.HOLD_CYC(HOLD)) uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .strobe_i (strobe),
        .en_i     (en),
        .tens_i   (tens),
        .units_i  (units),
        .early_o  (early)
    );

    always @(negedge clk) begin
        if (early && !prev_e) rises++;
        if (early) begin
            run_len++;
        end else if (prev_e) begin
            runs++;
            if (run_len != HOLD) run_bad++;
            run_len = 0;
        end
        prev_e = early;
    end

    function automatic int clampd(input int d);
        return (d > 9) ? 9 : d;
    endfunction

    function automatic int exp_rate(input int t, input int u);
        return 10 * clampd(t) + clampd(u);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        strobe = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic e);
        int gap;
        gap = $urandom_range(8, 4);
        @(negedge clk);
        strobe = 1'b1;
        en = e;
        @(negedge clk);
        strobe = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // n enabled strobes; optional disabled strobes mixed in; group spread checked
    task automatic window(input int n, input bit mix, input int m1,
                          output int total, output int grp_bad);
        int start, gstart, g;
        start = rises;
        gstart = rises;
        grp_bad = 0;
        for (int k = 0; k < n; k++) begin
            if (mix && $urandom_range(3, 0) == 0) send(1'b0);
            send(1'b1);
            if ((k % 10) == 9) begin
                g = rises - gstart;
                if (g != m1 && g != m1 + 1) grp_bad++;
                gstart = rises;
            end
        end
        total = rises - start;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int tot, gb, r0;
        int st_t[5];
        int st_u[5];
        st_t = '{0, 0, 3, 5, 9};
        st_u = '{0, 1, 2, 0, 9};
        void'($urandom(32'd20251));

        do_reset();
        chk("R7 early low after reset", int'(early), 0);

        for (int s = 0; s < 5; s++) begin
            tens = 4'(st_t[s]);
            units = 4'(st_u[s]);
            do_reset();
            for (int w = 0; w < 2; w++) begin
                window(100, 1'b0, st_t[s], tot, gb);
                chk((s == 0) ? "R4 zero rate count" : "R2 window count",
                    tot, exp_rate(st_t[s], st_u[s]));
                chk("R6 group spread", gb, 0);
            end
        end

        // R1: third window at 32 still gives 32
        tens = 4'd3; units = 4'd2;
        window(100, 1'b0, 3, tot, gb);
        chk("R1 setting 32 third window", tot, 32);

        // R4: out-of-range digits clamp to 9
        tens = 4'd12; units = 4'd11;
        do_reset();
        window(100, 1'b0, 9, tot, gb);
        chk("R4 clamp to 99", tot, 99);

        // R3: disabled strobes ignored, window position kept
        tens = 4'd9; units = 4'd9;
        do_reset();
        r0 = rises;
        for (int k = 0; k < 40; k++) send(1'b0);
        chk("R3 disabled no output", rises - r0, 0);
        window(100, 1'b1, 9, tot, gb);
        chk("R3 mixed window count", tot, 99);
        chk("R3 mixed group spread", gb, 0);

        // R7: reset mid-window restarts the window
        tens = 4'd3; units = 4'd2;
        do_reset();
        for (int k = 0; k < 37; k++) send(1'b1);
        repeat (5) @(negedge clk);
        do_reset();
        chk("R7 early low after mid reset", int'(early), 0);
        window(100, 1'b0, 3, tot, gb);
        chk("R7 window after mid reset", tot, 32);
        chk("R7 spread after mid reset", gb, 0);

        // R1/R2: random settings including out-of-range digits
        for (int t = 0; t < 6; t++) begin
            int rt, ru;
            rt = $urandom_range(15, 0);
            ru = $urandom_range(15, 0);
            tens = 4'(rt);
            units = 4'(ru);
            do_reset();
            window(100, 1'b1, clampd(rt), tot, gb);
            chk("R1 random window count", tot, exp_rate(rt, ru));
            chk("R6 random group spread", gb, 0);
        end

        repeat (10) @(negedge clk);
        chk("R5 hold length violations", run_bad, 0);
        chk("R5 pulses observed", int'(runs > 0), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule